// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked system and an asynchronous 32K x 8 static RAM with active-low chip select, output gate and write strobe, and one shared bidirectional byte bus. A single-word request comes in through a valid/ready handshake with a 15-bit address, a direction flag and a write byte. The block then drives the RAM pins through a fixed series of phases and returns read bytes with a one-cycle valid strobe.

Each phase lasts a whole number of clock cycles. The count comes from a nanosecond limit divided by the clock period, rounded up, and is never less than one. Write pulse width, data setup, address-to-end-of-write, write cycle time, address access time, output-gate access time and bus release after the output gate closes are all parameters. The shared bus is split at the block edge into a byte out, a drive enable and a byte in, and the pad ring joins them. Every RAM control pin comes straight from a flop.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, the chip select, output gate and write strobe are 1 (inactive), the bus drive enable is 0 and rd_valid is 0.
- R2: A read keeps the chip select at 0, the output gate at 0 and the write strobe at 1 for RD_CYC = max(ceil(T_AA/T), ceil(T_OE/T)) cycles, which is 6 at the default 10 ns period. The address stays stable while the chip select is 0.
- R3: Read data is sampled at the clock edge that ends the last access cycle. It appears on rd_data together with a one-cycle rd_valid pulse, and that pulse is high RD_CYC+1 cycles after the accepting edge.
- R4: A write begins with exactly one setup cycle. In it the chip select is 0, the write strobe is 1 and the bus is driven. The write strobe is 0 in the following cycles. The output gate stays at 1 for the whole write.
- R5: The write strobe stays at 0 for exactly WP_CYC = max(ceil(T_WP/T), ceil(T_AW/T)-1, ceil(T_DW/T)-1) cycles, which is 4 by default. The low pulse is therefore at least T_WP long. When the strobe rises, the data has been driven for at least T_DW and the address has been valid for at least T_AW.
- R6: After the write strobe rises, all controls stay at 1 for REC_CYC = max(1, ceil(T_WC/T)-1-WP_CYC) cycles. req_ready returns 2+WP_CYC+REC_CYC cycles after the accepting edge (7 by default). Consecutive chip-select falls are at least T_WC apart.
- R7: The bus drive enable is 1 only while the output gate is 1 and the chip select is 0. It is set only in the setup cycle and the strobe-low cycles. It drops at the same edge at which the write strobe rises.
- R8: After the output gate rises, the bus drive enable stays at 0 for at least HZ_CYC = ceil(T_OHZ/T) cycles. After a read, req_ready returns RD_CYC+HZ_CYC+1 cycles after the accepting edge (9 by default).
- R9: req_ready is 0 from the cycle after the accepting edge until the access is complete. It is always 0 while the chip select is 0.
- R10: A byte written to any address, including 0x0000 and 0x7FFF and the values 0x00 and 0xFF, is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle strobe marking new rd_data |
| sram_addr | output | 15 | RAM address pins |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output gate, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_dq_out | output | 8 | Byte to drive onto the shared bus |
| sram_dq_oe | output | 1 | Drive enable for the shared bus |
| sram_dq_in | input | 8 | Value seen on the shared bus |

## Verification
With the default 10 ns period, the read strobe rd_valid is due 7 cycles after the accepting edge. req_ready comes back 9 cycles after a read and 7 cycles after a write. The bench counts falling clock edges from the edge that accepted a request and compares these counts with latencies it derives from the nanosecond limits with its own rounding. It also samples the pin levels at each falling edge against the phase expected for that cycle. Separately, a RAM model timestamps every pin transition and measures the real intervals at the rising write strobe, the read strobe, each chip-select fall and each bus-drive start, so each nanosecond limit is checked directly rather than only through cycle counts.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  localparam int unsigned DEF_PERIOD_NS = 10;
  localparam int unsigned DEF_T_WP_NS   = 40;
  localparam int unsigned DEF_T_DW_NS   = 25;
  localparam int unsigned DEF_T_AW_NS   = 50;
  localparam int unsigned DEF_T_WC_NS   = 55;
  localparam int unsigned DEF_T_AA_NS   = 55;
  localparam int unsigned DEF_T_OE_NS   = 30;
  localparam int unsigned DEF_T_OHZ_NS  = 20;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RD_ACC, PH_RD_REL, PH_WR_SET, PH_WR_PULSE, PH_WR_REC
  } sram_phase_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } sram_pins_t;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Whole cycles covering a nanosecond limit, never below one.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned rd_acc_cyc(int unsigned taa, int unsigned toe,
                                             int unsigned period);
    return umax(ns_to_cyc(taa, period), ns_to_cyc(toe, period));
  endfunction

  // The setup cycle already counts toward address-valid and data-valid time.
  function automatic int unsigned wr_pulse_cyc(int unsigned twp, int unsigned taw,
                                               int unsigned tdw, int unsigned period);
    int unsigned p;
    p = ns_to_cyc(twp, period);
    p = umax(p, ns_to_cyc(taw, period) - 1);
    p = umax(p, ns_to_cyc(tdw, period) - 1);
    return umax(p, 1);
  endfunction

  function automatic int unsigned wr_rec_cyc(int unsigned twc, int unsigned pulse,
                                             int unsigned period);
    int unsigned full;
    full = ns_to_cyc(twc, period);
    return (full > pulse + 2) ? (full - 1 - pulse) : 1;
  endfunction

  function automatic sram_pins_t pins_for(sram_phase_e ph);
    sram_pins_t p;
    case (ph)
      PH_RD_ACC:   p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
      PH_WR_SET:   p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
      PH_WR_PULSE: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
      default:     p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
`timescale 1ns/1ps
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 6,
  parameter int unsigned HZ_CYC  = 2,
  parameter int unsigned WP_CYC  = 4,
  parameter int unsigned REC_CYC = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_we,
  output sram_phase_e phase_q,
  output sram_phase_e phase_d,
  output logic        phase_done
);

  localparam int unsigned MAX_LEN = umax(umax(RD_CYC, HZ_CYC), umax(WP_CYC, REC_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [CNT_W-1:0] last_index(sram_phase_e ph);
    case (ph)
      PH_RD_ACC:   return CNT_W'(RD_CYC - 1);
      PH_RD_REL:   return CNT_W'(HZ_CYC - 1);
      PH_WR_PULSE: return CNT_W'(WP_CYC - 1);
      PH_WR_REC:   return CNT_W'(REC_CYC - 1);
      default:     return '0;
    endcase
  endfunction

  assign phase_done = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:     if (start) phase_d = start_we ? PH_WR_SET : PH_RD_ACC;
      PH_RD_ACC:   if (phase_done) phase_d = PH_RD_REL;
      PH_RD_REL:   if (phase_done) phase_d = PH_IDLE;
      PH_WR_SET:   phase_d = PH_WR_PULSE;
      PH_WR_PULSE: if (phase_done) phase_d = PH_WR_REC;
      PH_WR_REC:   if (phase_done) phase_d = PH_IDLE;
      default:     phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    if (phase_d != phase_q)  cnt_d = last_index(phase_d);
    else if (!phase_done)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_phase_e       phase_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              sram_dq_oe
);

  sram_pins_t pins_q;
  sram_pins_t pins_next;

  // Pins follow the phase entered at this edge, straight from flops.
  assign pins_next = pins_for(phase_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q      <= pins_for(PH_IDLE);
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else begin
      pins_q <= pins_next;
      if (accept) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
    end
  end

  assign sram_ce_n  = pins_q.ce_n;
  assign sram_oe_n  = pins_q.oe_n;
  assign sram_we_n  = pins_q.we_n;
  assign sram_dq_oe = pins_q.dq_oe;

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = DEF_PERIOD_NS,
  parameter int unsigned T_WP_NS       = DEF_T_WP_NS,
  parameter int unsigned T_DW_NS       = DEF_T_DW_NS,
  parameter int unsigned T_AW_NS       = DEF_T_AW_NS,
  parameter int unsigned T_WC_NS       = DEF_T_WC_NS,
  parameter int unsigned T_AA_NS       = DEF_T_AA_NS,
  parameter int unsigned T_OE_NS       = DEF_T_OE_NS,
  parameter int unsigned T_OHZ_NS      = DEF_T_OHZ_NS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned RD_CYC  = rd_acc_cyc(T_AA_NS, T_OE_NS, CLK_PERIOD_NS);
  localparam int unsigned HZ_CYC  = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC  = wr_pulse_cyc(T_WP_NS, T_AW_NS, T_DW_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC = wr_rec_cyc(T_WC_NS, WP_CYC, CLK_PERIOD_NS);

  sram_phase_e phase_q, phase_d;
  logic        phase_done;

  // Named internal events, also watched by the checker.
  logic accept_evt;
  logic capture_evt;

  assign req_ready   = (phase_q == PH_IDLE);
  assign accept_evt  = req_valid && req_ready;
  assign capture_evt = (phase_q == PH_RD_ACC) && phase_done;

  sram_phase_seq #(
    .RD_CYC (RD_CYC),
    .HZ_CYC (HZ_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_evt),
    .start_we  (req_we),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .phase_done(phase_done)
  );

  sram_pin_drv #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) drv_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_d    (phase_d),
    .accept     (accept_evt),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .sram_addr  (sram_addr),
    .sram_dq_out(sram_dq_out),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W)
  ) cap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture_evt),
    .dq_in   (sram_dq_in),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic              accept_evt,
  input logic              capture_evt
);

  localparam int unsigned N_WP = wr_pulse_cyc(DEF_T_WP_NS, DEF_T_AW_NS, DEF_T_DW_NS, DEF_PERIOD_NS);
  localparam int unsigned N_HZ = ns_to_cyc(DEF_T_OHZ_NS, DEF_PERIOD_NS);

  logic [7:0] we_low_run;
  logic [7:0] oe_high_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_run  <= '0;
      oe_high_run <= 8'hFF;
    end else begin
      we_low_run  <= sram_we_n ? 8'd0 : we_low_run + 8'd1;
      if (!sram_oe_n)                oe_high_run <= 8'd0;
      else if (oe_high_run != 8'hFF) oe_high_run <= oe_high_run + 8'd1;
    end
  end

  // R2
  rd_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ce_n && sram_we_n));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R3
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> rd_valid);
  // R4
  wr_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));
  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_run == 8'(N_WP)));
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_ce_n));
  // R7
  dq_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && sram_we_n) |=> !sram_we_n);
  // R8
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_high_run >= 8'(N_HZ)));
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(15)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_dq_oe (sram_dq_oe),
  .accept_evt (accept_evt),
  .capture_evt(capture_evt)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

  localparam int CLK_NS = 10;

  // Bench-side rounding: smallest n with n*CLK_NS >= ns, at least 1.
  function automatic int span(int ns);
    int n = 1;
    while (n * CLK_NS < ns) n++;
    return n;
  endfunction

  function automatic int bigger(int a, int b);
    return (a > b) ? a : b;
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_out, sram_dq_in;

  int checks = 0;
  int errors = 0;
  int e_rd, e_hz, e_wp, e_rec;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural RAM: drives the bus only when selected, gated and not writing.
  logic [7:0] ram [int];
  logic [7:0] scoreboard [int];
  logic       ram_drive;
  logic [7:0] ram_q;
  assign ram_drive = !sram_ce_n && !sram_oe_n && sram_we_n;
  always @* ram_q = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : 8'h5C;
  assign sram_dq_in = sram_dq_oe ? sram_dq_out : (ram_drive ? ram_q : 8'h00);

  time t_addr = 0, t_we_fall = 0, t_oe_fall = 0, t_oe_rise = -1000, t_dq_rise = 0;
  time t_ce_fall = -1000;
  bit  we_armed = 0;

  always @(sram_addr) t_addr = $time;
  always @(negedge sram_oe_n) t_oe_fall = $time;
  always @(posedge sram_oe_n) t_oe_rise = $time;
  always @(negedge sram_we_n) begin t_we_fall = $time; we_armed = 1; end
  always @(posedge sram_dq_oe) begin
    t_dq_rise = $time;
    // R8: bus released by the RAM before it is driven
    check(($time - t_oe_rise) >= 20, "R8 turnaround ns", int'($time - t_oe_rise), 20);
  end
  always @(negedge sram_ce_n) begin
    // R6: chip-select falls spaced by the cycle time
    check(($time - t_ce_fall) >= 55, "R6 cycle ns", int'($time - t_ce_fall), 55);
    t_ce_fall = $time;
  end
  always @(posedge sram_we_n) if (we_armed) begin
    we_armed = 0;
    // R5: pulse width, data setup and address-valid at end of write
    check(($time - t_we_fall) >= 40, "R5 pulse ns", int'($time - t_we_fall), 40);
    check(($time - t_dq_rise) >= 25, "R5 data setup ns", int'($time - t_dq_rise), 25);
    check(($time - t_addr) >= 50, "R5 addr valid ns", int'($time - t_addr), 50);
    ram[int'(sram_addr)] = sram_dq_out;
  end
  always @(posedge rd_valid) begin
    // R2: access times met at the capture edge
    check(($time - t_addr) >= 55, "R2 addr access ns", int'($time - t_addr), 55);
    check(($time - t_oe_fall) >= 30, "R2 gate access ns", int'($time - t_oe_fall), 30);
  end

  // One access; n counts falling edges after the accepting edge.
  task automatic access(bit we, logic [14:0] a, logic [7:0] d, output logic [7:0] got);
    int n;
    int lat_v;
    bit pins_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    n = 1; lat_v = -1; pins_ok = 1; got = 'x;
    // R9: busy right after acceptance
    check(!req_ready, "R9 ready low", int'(req_ready), 0);
    while (!req_ready && n < 40) begin
      if (rd_valid) begin
        if (lat_v < 0) lat_v = n;
        got = rd_data;
      end
      if (!we) begin
        if (n <= e_rd) pins_ok &= (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe);
        else           pins_ok &= (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe);
      end else begin
        if (n == 1)              pins_ok &= (!sram_ce_n && sram_oe_n && sram_we_n && sram_dq_oe);
        else if (n <= 1 + e_wp)  pins_ok &= (!sram_ce_n && sram_oe_n && !sram_we_n && sram_dq_oe);
        else                     pins_ok &= (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe);
      end
      @(negedge clk);
      n++;
    end
    if (we) begin
      check(pins_ok, "R4 write pin phases", int'(pins_ok), 1);
      check(n == 2 + e_wp + e_rec, "R6 write ready latency", n, 2 + e_wp + e_rec);
    end else begin
      check(pins_ok, "R2 read pin phases", int'(pins_ok), 1);
      check(lat_v == e_rd + 1, "R3 rd_valid latency", lat_v, e_rd + 1);
      check(n == e_rd + e_hz + 1, "R8 read ready latency", n, e_rd + e_hz + 1);
    end
  endtask

  task automatic do_write(logic [14:0] a, logic [7:0] d);
    logic [7:0] unused;
    access(1'b1, a, d, unused);
    scoreboard[int'(a)] = d;
  endtask

  task automatic do_read(logic [14:0] a);
    logic [7:0] got;
    logic [7:0] exp;
    access(1'b0, a, 8'h00, got);
    exp = scoreboard.exists(int'(a)) ? scoreboard[int'(a)] : 8'h5C;
    // R10: read-back matches last write
    check(got === exp, "R10 read-back", int'(got), int'(exp));
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int wlist[$];
    void'($urandom(32'h1D5E));
    e_rd  = bigger(span(55), span(30));
    e_hz  = span(20);
    e_wp  = bigger(span(40), bigger(span(50) - 1, span(25) - 1));
    e_rec = bigger(1, span(55) - 1 - e_wp);

    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check(req_ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid,
          "R1 reset pins", 0, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid,
          "R1 after reset", 0, 0);

    // Directed corners: extreme addresses and data, read then write back to back.
    do_write(15'h0000, 8'h00);
    do_write(15'h7FFF, 8'hFF);
    do_read(15'h0000);
    do_read(15'h7FFF);
    do_write(15'h0000, 8'hA3);
    do_read(15'h0000);
    do_write(15'h7FFF, 8'h3C);
    do_read(15'h7FFF);
    wlist.push_back(0);
    wlist.push_back(32767);

    for (int i = 0; i < 300; i++) begin
      if (($urandom % 2) == 0) begin
        logic [14:0] a;
        a = 15'($urandom);
        do_write(a, 8'($urandom));
        wlist.push_back(int'(a));
      end else begin
        do_read(15'(wlist[$urandom_range(0, wlist.size() - 1)]));
      end
    end

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule